// File: doc/BRIEF.md
# Three-Channel Audio Interval Timer

This block supplies three programmable interval timers to an audio processor. A prescaler divides the system clock into two time bases. The fast base ticks once every `FAST_DIV` system clocks. The slow base ticks once every eighth fast tick. Channels 0 and 1 run on the slow base and channel 2 runs on the fast base.

Each channel holds an 8-bit interval limit and an 8-bit running count. The running count advances on every tick of the channel's base while the channel is enabled. When the count reaches the limit, the count starts over from zero and the channel bumps a 4-bit event tally.

A host reaches the block through a plain register port. The host sets the enables and the limits, and polls the tallies. Reading a tally also empties it, so the value returned is the number of events since the last poll, modulo 16.

Top module: `atim_top`

## Requirements
- R1: After reset, every register reads as 0: the enables, the limits and the tallies.
- R2: The fast base ticks once every `FAST_DIV` clocks and the slow base ticks once every 8 fast ticks. Channels 0 and 1 step on the slow base and channel 2 steps on the fast base.
- R3: On a tick of an enabled channel whose running count plus one reaches the limit, the running count becomes 0 and the tally rises by one. Otherwise the running count rises by one.
- R4: A limit of 0 acts as a limit of 256.
- R5: A tally is 4 bits wide and goes from 15 back to 0.
- R6: While a channel's enable is 0, its running count and its tally hold their values. A read of the tally still empties it.
- R7: When a channel's enable changes from 0 to 1, its running count and its tally are set to 0 on the next clock edge. That edge ignores any tick.
- R8: A read of a tally returns the tally's value on `bus_rdata` one cycle after `bus_rd` is sampled. The same edge sets the tally to 0.
- R9: If a read empties a tally on the same edge that an event bumps it, the read returns the old value and the tally becomes 1, so no event is lost.
- R10: The register map is as follows. Address 0 holds the enables, with bit n for channel n. Addresses 1, 2 and 3 hold the limits of channels 0, 1 and 2, and can be read back. Addresses 4, 5 and 6 hold the tallies of channels 0, 1 and 2, in the low 4 bits. Address 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_rd` |

## Verification
A host read that empties a tally can land on the same clock edge as an event that bumps it. To provoke this, channel 2 runs with a limit of 1, so it produces an event on every fast tick. Its tally is then read on every cycle for 64 cycles, which places a read on top of every event. The values returned are summed together with one final read. The sum must equal the number of fast ticks in the window, which the bench knows exactly. Any event dropped by the collision shows up as a shortfall in the sum.

// File: rtl/atim_pkg.sv
package atim_pkg;
  localparam int NUM_CH    = 3;
  localparam int CNT_W     = 8;
  localparam int TALLY_W   = 4;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int SLOW_MULT = 8;

  localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(0);
  localparam int                A_LIM_BASE = 1;
  localparam int                A_TAL_BASE = 1 + NUM_CH;

  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [TALLY_W-1:0] tally_t;
endpackage

// File: rtl/atim_prescaler.sv
module atim_prescaler #(
  parameter int FAST_DIV = 4,
  parameter int SLOW_MULT = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic fast_tick,
  output logic slow_tick
);
  localparam int FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
  localparam int SW = (SLOW_MULT > 1) ? $clog2(SLOW_MULT) : 1;

  logic [FW-1:0] div_q;
  logic [SW-1:0] sub_q;

  assign fast_tick = (div_q == FW'(FAST_DIV - 1));
  assign slow_tick = fast_tick && (sub_q == SW'(SLOW_MULT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sub_q <= '0;
    end else begin
      div_q <= fast_tick ? '0 : div_q + 1'b1;
      if (fast_tick)
        sub_q <= (sub_q == SW'(SLOW_MULT - 1)) ? '0 : sub_q + 1'b1;
    end
  end

  // R2: a slow tick never occurs without a fast tick
  assert_slow_in_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |-> fast_tick);
  // R2: fast ticks are never back to back when the divider exceeds one
  assert_fast_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_tick && FAST_DIV > 1) |=> !fast_tick);
endmodule

// File: rtl/atim_channel.sv
module atim_channel
  import atim_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  cnt_t   limit,
  input  logic   tick,
  input  logic   clr_req,
  output tally_t tally
);
  logic         en_d;
  cnt_t         run_q;
  logic [CNT_W:0] lim_ext;
  logic [CNT_W:0] nxt;
  logic         restart;
  logic         step;
  logic         hit;

  assign lim_ext = (limit == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, limit};
  assign nxt     = {1'b0, run_q} + 1'b1;
  assign restart = enable && !en_d;
  assign step    = enable && tick && !restart;
  assign hit     = step && (nxt >= lim_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d  <= 1'b0;
      run_q <= '0;
      tally <= '0;
    end else begin
      en_d <= enable;
      if (restart) begin
        run_q <= '0;
        tally <= '0;
      end else begin
        if (step)
          run_q <= hit ? '0 : nxt[CNT_W-1:0];
        case ({clr_req, hit})
          2'b10:   tally <= '0;
          2'b11:   tally <= tally_t'(1);
          2'b01:   tally <= tally + 1'b1;
          default: tally <= tally;
        endcase
      end
    end
  end

  // R6: a disabled channel with no read holds its state
  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !clr_req) |=> ($stable(tally) && $stable(run_q)));
  // R7: a rising enable leaves state at zero
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> (tally == '0 && run_q == '0));
  // R8 / R9: a read leaves at most the one event of that edge
  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (tally <= tally_t'(1)));
  // R5: the tally wraps from 15 to 0
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tally == '1 && hit && !clr_req) |=> (tally == '0));
endmodule

// File: rtl/atim_regs.sv
module atim_regs
  import atim_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_CH-1:0][TALLY_W-1:0] tallies,
  output logic [NUM_CH-1:0]          en_q,
  output logic [NUM_CH-1:0][CNT_W-1:0] lim_q,
  output logic [NUM_CH-1:0]          clr_vec
);
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (bus_addr == A_CTRL)
      rd_val[NUM_CH-1:0] = en_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(A_LIM_BASE + i))
        rd_val = DATA_W'(lim_q[i]);
      if (bus_addr == ADDR_W'(A_TAL_BASE + i))
        rd_val = DATA_W'(tallies[i]);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      clr_vec[i] = bus_rd && (bus_addr == ADDR_W'(A_TAL_BASE + i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      lim_q     <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_rd)
        bus_rdata <= rd_val;
      if (bus_wr) begin
        if (bus_addr == A_CTRL)
          en_q <= bus_wdata[NUM_CH-1:0];
        for (int i = 0; i < NUM_CH; i++)
          if (bus_addr == ADDR_W'(A_LIM_BASE + i))
            lim_q[i] <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  // R10: a control write lands in the enables
  assert_ctrl_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL) |=> (en_q == $past(bus_wdata[NUM_CH-1:0])));
  // R10: at most one tally is emptied per read
  assert_one_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));
endmodule

// File: rtl/atim_top.sv
module atim_top
  import atim_pkg::*;
#(
  parameter int               FAST_DIV  = 4,
  parameter logic [NUM_CH-1:0] FAST_MASK = 3'b100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic fast_tick;
  logic slow_tick;
  logic [NUM_CH-1:0]                en_q;
  logic [NUM_CH-1:0][CNT_W-1:0]     lim_q;
  logic [NUM_CH-1:0]                clr_vec;
  logic [NUM_CH-1:0][TALLY_W-1:0]   tallies;
  logic [NUM_CH-1:0]                ch_tick;

  atim_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_MULT(SLOW_MULT)) u_pre (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick)
  );

  atim_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tallies(tallies), .en_q(en_q), .lim_q(lim_q), .clr_vec(clr_vec)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    if (FAST_MASK[g]) begin : g_fast
      assign ch_tick[g] = fast_tick;
    end else begin : g_slow
      assign ch_tick[g] = slow_tick;
    end
    atim_channel u_ch (
      .clk(clk), .rst_n(rst_n), .enable(en_q[g]), .limit(lim_q[g]),
      .tick(ch_tick[g]), .clr_req(clr_vec[g]), .tally(tallies[g])
    );
  end
endmodule

// File: tb/atim_top_tb_top.sv
module atim_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  int         cyc = 0;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  atim_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic [7:0] l0, l1, l2;
    logic [7:0] en;
    logic [7:0] per;
    logic [3:0] e0, e1, e2;
  } vec_t;

  // per = slow periods; channel 2 sees 8 fast ticks per slow period
  localparam vec_t VEC [6] = '{
    '{8'd1, 8'd2, 8'd3, 8'd7, 8'd5,  4'd5, 4'd2, 4'd13},
    '{8'd1, 8'd1, 8'd1, 8'd7, 8'd2,  4'd2, 4'd2, 4'd0},
    '{8'd3, 8'd1, 8'd5, 8'd5, 8'd7,  4'd2, 4'd0, 4'd11},
    '{8'd2, 8'd4, 8'd7, 8'd2, 8'd9,  4'd0, 4'd2, 4'd0},
    '{8'd1, 8'd1, 8'd1, 8'd7, 8'd3,  4'd3, 4'd3, 4'd8},
    '{8'd0, 8'd1, 8'd0, 8'd7, 8'd40, 4'd0, 4'd8, 4'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
    bus_rd = 1'b0;
  endtask

  // phase 13 of 32 sits away from every fast and slow tick edge
  task automatic align();
    while (cyc % 32 != 13) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    int sum;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of every address
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reset read", v, 0);
    end

    // R10: limit readback and ctrl readback
    wr(3'd2, 8'hA5);
    rd(3'd2, v); check("R10 limit1 readback", v, 8'hA5);
    wr(3'd0, 8'h05);
    rd(3'd0, v); check("R10 ctrl readback", v, 5);
    rd(3'd7, v); check("R10 unused address", v, 0);

    // Vector table: R2 R3 R4 R5 R6 R8 R10
    foreach (VEC[i]) begin
      wr(3'd0, 8'h00);
      wr(3'd1, VEC[i].l0);
      wr(3'd2, VEC[i].l1);
      wr(3'd3, VEC[i].l2);
      align();
      wr(3'd0, VEC[i].en);
      repeat (32 * int'(VEC[i].per) - 16) @(negedge clk);
      align();
      rd(3'd6, v); check("R2/R3/R4/R5 tally2", v, int'(VEC[i].e2));
      rd(3'd5, v); check("R2/R3/R6 tally1", v, int'(VEC[i].e1));
      rd(3'd4, v); check("R2/R3/R4 tally0", v, int'(VEC[i].e0));
      rd(3'd4, v); check("R8 tally0 emptied by read", v, 0);
    end

    // R6: disabling freezes the tally
    wr(3'd0, 8'h00);
    wr(3'd1, 8'd1);
    align();
    wr(3'd0, 8'h01);
    repeat (96 - 16) @(negedge clk);
    align();
    wr(3'd0, 8'h00);
    repeat (40) @(negedge clk);
    align();
    repeat (20) @(negedge clk);
    align();
    rd(3'd4, v); check("R6 frozen tally0", v, 3);

    // R7: rising enable clears tally and running count
    wr(3'd1, 8'd2);
    align();
    wr(3'd0, 8'h01);
    repeat (96 - 16) @(negedge clk);
    align();
    wr(3'd0, 8'h00);
    repeat (20) @(negedge clk);
    align();
    wr(3'd0, 8'h01);
    repeat (20) @(negedge clk);
    align();
    rd(3'd4, v); check("R7 restart after one tick", v, 0);
    repeat (20) @(negedge clk);
    align();
    rd(3'd4, v); check("R7 event after two ticks", v, 1);

    // R9: read colliding with event, channel 2 limit 1
    wr(3'd0, 8'h00);
    wr(3'd3, 8'd1);
    align();
    wr(3'd0, 8'h04);
    repeat (20) @(negedge clk);
    align();
    sum = 0;
    bus_rd = 1'b1; bus_addr = 3'd6;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      sum += int'(bus_rdata);
    end
    bus_rd = 1'b0;
    repeat (10) @(negedge clk);
    align();
    rd(3'd6, v);
    sum += v;
    check("R9 no event lost on read collision", sum, 32);

    finish_run();
  end
endmodule